// File: doc/BRIEF.md
# Interrupt Destination Matcher

This block decides which of a set of local interrupt controllers accept an inter-processor message. On a send strobe it looks at the low and high command words of the message and at the sender's index. For every target it also looks at three things: an 8-bit physical ID, an 8-bit logical ID and a 4-bit destination-format model. From these it forms one match bit per target.

Addressing can come from a two-bit shorthand (self, everyone, everyone but the sender) or from the 8-bit destination field. The destination field is read either as a physical ID, with a broadcast value, or as a logical mask in flat or cluster form. When the message asks for lowest-priority delivery, the match vector is reduced to a single target, the highest-indexed one that matched. The result is registered and marked with a one-cycle valid pulse. The surrounding fabric then hands the vector to the selected controllers.

Top module: `ipi_dest_match`

## Requirements
- R1: While rst_n is low at a clock edge, match_o becomes all zeros and valid_o becomes 0.
- R2: valid_o is high for exactly the one cycle after each cycle in which send_i was sampled high. match_o takes its new value in that same cycle and keeps it until the next send.
- R3: Shorthand cmd_lo_i[19:18] = 01 selects only the target whose index equals sender_i.
- R4: Shorthand 10 selects every target. Shorthand 11 selects every target except the one at sender_i.
- R5: With shorthand 00 and cmd_lo_i[11] = 0 (physical), target k matches when the destination equals 8'hFF or equals its physical ID.
- R6: With shorthand 00, cmd_lo_i[11] = 1 and a target model of 4'hF (flat), the target matches when the bitwise AND of its logical ID and the destination is non-zero.
- R7: With shorthand 00, cmd_lo_i[11] = 1 and a target model of 4'h0 (cluster), two conditions must both hold for a match. The upper nibbles of the logical ID and the destination must be equal. The AND of their lower nibbles must be non-zero.
- R8: In logical mode, a target whose model is neither 4'hF nor 4'h0 never matches.
- R9: When cmd_lo_i[10:8] = 001 (lowest priority), match_o has only the highest-indexed matching bit set, and all zeros when nothing matched. Any other value of cmd_lo_i[10:8] leaves the full match vector.
- R10: The destination is cmd_hi_i[31:24]. All other bits of cmd_hi_i have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| send_i | input | 1 | Evaluate the message this cycle |
| cmd_lo_i | input | 32 | Low command word: shorthand, destination mode, delivery mode |
| cmd_hi_i | input | 32 | High command word: destination in [31:24] |
| sender_i | input | SND_W (2) | Index of the sending controller |
| tgt_id_i | input | N_TGT*8 (32) | Physical IDs, target k in [8k+7:8k] |
| tgt_lid_i | input | N_TGT*8 (32) | Logical IDs, target k in [8k+7:8k] |
| tgt_fmt_i | input | N_TGT*4 (16) | Format models, target k in [4k+3:4k] |
| match_o | output | N_TGT (4) | Registered selection vector |
| valid_o | output | 1 | One-cycle pulse marking a fresh match_o |

## Verification
The hardest case to reach from the ports is lowest-priority delivery in which several targets match at once through logical addressing. To get there, the targets must share cluster nibbles or overlapping flat masks while the delivery field holds exactly 001. The random stimulus draws logical IDs and destinations from a small pool of values with dense bit overlap, and it mixes flat, cluster and invalid models across the targets. This makes multi-hit vectors common enough for the highest-index reduction to be exercised. Directed cases add the empty-match lowest-priority send and the physical broadcast value.

// File: rtl/ipi_match_pkg.sv
// Shared types and encodings for the interrupt destination matcher.
// Assumes the command word layout fixed by the requirements.
package ipi_match_pkg;

    typedef enum logic [1:0] {
        SH_DEST   = 2'b00,
        SH_SELF   = 2'b01,
        SH_ALL    = 2'b10,
        SH_OTHERS = 2'b11
    } shorthand_e;

    typedef struct packed {
        shorthand_e  sh;
        logic        logical;
        logic [2:0]  dmode;
        logic [7:0]  dest;
    } ipi_cmd_t;

    localparam logic [2:0] DM_LOWEST   = 3'b001;
    localparam logic [3:0] FMT_FLAT    = 4'hF;
    localparam logic [3:0] FMT_CLUSTER = 4'h0;

endpackage

// File: rtl/ipi_cmd_decode.sv
// Pulls the addressing fields out of the two command words.
// Assumes 32-bit words; bits not listed are ignored.
module ipi_cmd_decode
    import ipi_match_pkg::*;
(
    input  logic [31:0] cmd_lo_i,
    input  logic [31:0] cmd_hi_i,
    output ipi_cmd_t    cmd_o
);
    logic unused_bits;

    // Field extraction from the low and high words.
    always_comb begin
        cmd_o.sh      = shorthand_e'(cmd_lo_i[19:18]);
        cmd_o.logical = cmd_lo_i[11];
        cmd_o.dmode   = cmd_lo_i[10:8];
        cmd_o.dest    = cmd_hi_i[31:24];
    end

    assign unused_bits = ^{cmd_lo_i[31:20], cmd_lo_i[17:12], cmd_lo_i[7:0], cmd_hi_i[23:0]};

endmodule

// File: rtl/ipi_target_match.sv
// Decides whether one target is addressed by a decoded command.
// Assumes is_self_i is already resolved against the sender index.
module ipi_target_match
    import ipi_match_pkg::*;
(
    input  ipi_cmd_t    cmd_i,
    input  logic        is_self_i,
    input  logic [7:0]  phys_id_i,
    input  logic [7:0]  log_id_i,
    input  logic [3:0]  fmt_i,
    output logic        hit_o
);
    logic phys_hit;
    logic log_hit;

    // Physical compare, with broadcast.
    always_comb begin
        phys_hit = (cmd_i.dest == 8'hFF) || (cmd_i.dest == phys_id_i);
    end

    // Logical compare chosen by the format model.
    always_comb begin
        case (fmt_i)
            FMT_FLAT:    log_hit = |(log_id_i & cmd_i.dest);
            FMT_CLUSTER: log_hit = (log_id_i[7:4] == cmd_i.dest[7:4]) &&
                                   (|(log_id_i[3:0] & cmd_i.dest[3:0]));
            default:     log_hit = 1'b0;
        endcase
    end

    // Shorthand selects the source of the decision.
    always_comb begin
        case (cmd_i.sh)
            SH_DEST:   hit_o = cmd_i.logical ? log_hit : phys_hit;
            SH_SELF:   hit_o = is_self_i;
            SH_ALL:    hit_o = 1'b1;
            SH_OTHERS: hit_o = !is_self_i;
            default:   hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ipi_lowest_pick.sv
// Keeps only the highest-indexed set bit of a vector; zero stays zero.
// Assumes N is at least 1.
module ipi_lowest_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] pick_o
);
    // Scan upward so the last set bit wins.
    always_comb begin
        pick_o = '0;
        for (int k = 0; k < N; k++) begin
            if (req_i[k]) begin
                pick_o    = '0;
                pick_o[k] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ipi_dest_match.sv
// Top of the destination matcher: decodes the command, evaluates every
// target in parallel, optionally reduces to one target and registers
// the result with a valid pulse. Assumes sender_i < N_TGT.
module ipi_dest_match
    import ipi_match_pkg::*;
#(
    parameter int N_TGT = 4,
    localparam int SND_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 send_i,
    input  logic [31:0]          cmd_lo_i,
    input  logic [31:0]          cmd_hi_i,
    input  logic [SND_W-1:0]     sender_i,
    input  logic [N_TGT*8-1:0]   tgt_id_i,
    input  logic [N_TGT*8-1:0]   tgt_lid_i,
    input  logic [N_TGT*4-1:0]   tgt_fmt_i,
    output logic [N_TGT-1:0]     match_o,
    output logic                 valid_o
);
    ipi_cmd_t          cmd;
    logic [N_TGT-1:0]  raw_hit;
    logic [N_TGT-1:0]  one_hit;
    logic [N_TGT-1:0]  sel_hit;
    logic [N_TGT-1:0]  match_q;
    logic              valid_q;

    ipi_cmd_decode u_dec (
        .cmd_lo_i (cmd_lo_i),
        .cmd_hi_i (cmd_hi_i),
        .cmd_o    (cmd)
    );

    for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
        ipi_target_match u_tm (
            .cmd_i     (cmd),
            .is_self_i (sender_i == SND_W'(g)),
            .phys_id_i (tgt_id_i[g*8 +: 8]),
            .log_id_i  (tgt_lid_i[g*8 +: 8]),
            .fmt_i     (tgt_fmt_i[g*4 +: 4]),
            .hit_o     (raw_hit[g])
        );
    end

    ipi_lowest_pick #(.N(N_TGT)) u_pick (
        .req_i  (raw_hit),
        .pick_o (one_hit)
    );

    // Choose the reduced vector for lowest-priority delivery.
    always_comb begin
        sel_hit = (cmd.dmode == DM_LOWEST) ? one_hit : raw_hit;
    end

    // Register the result on a send and pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= send_i;
            if (send_i) begin
                match_q <= sel_hit;
            end
        end
    end

    assign match_o = match_q;
    assign valid_o = valid_q;

endmodule

// File: rtl/ipi_dest_match_chk.sv
// Property checker for the destination matcher, bound to the top.
module ipi_dest_match_chk #(
    parameter int N_TGT = 4,
    parameter int SND_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               send_i,
    input logic [31:0]        cmd_lo_i,
    input logic [SND_W-1:0]   sender_i,
    input logic [N_TGT-1:0]   match_o,
    input logic               valid_o
);
    localparam logic [N_TGT-1:0] ONE = N_TGT'(1);

    assert_valid_has_send_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(send_i));

    assert_send_gives_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        send_i |=> valid_o);

    assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(match_o));

    assert_self_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(cmd_lo_i[19:18] == 2'b01)) |-> (match_o == (ONE << $past(sender_i))));

    assert_all_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(cmd_lo_i[19:18] == 2'b10 && cmd_lo_i[10:8] != 3'b001)) |-> (&match_o));

    assert_lowest_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(cmd_lo_i[10:8] == 3'b001)) |-> $onehot0(match_o));

endmodule

bind ipi_dest_match ipi_dest_match_chk #(.N_TGT(N_TGT), .SND_W(SND_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .send_i   (send_i),
    .cmd_lo_i (cmd_lo_i),
    .sender_i (sender_i),
    .match_o  (match_o),
    .valid_o  (valid_o)
);

// File: tb/ipi_dest_match_test.sv
// Self-checking bench: directed corners plus seeded random messages.
module ipi_dest_match_test;
    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          send_i = 1'b0;
    logic [31:0]   cmd_lo_i = '0;
    logic [31:0]   cmd_hi_i = '0;
    logic [1:0]    sender_i = '0;
    logic [N*8-1:0] tgt_id_i = '0;
    logic [N*8-1:0] tgt_lid_i = '0;
    logic [N*4-1:0] tgt_fmt_i = '0;
    logic [N-1:0]  match_o;
    logic          valid_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ipi_dest_match #(.N_TGT(N)) uut (
        .clk(clk), .rst_n(rst_n), .send_i(send_i),
        .cmd_lo_i(cmd_lo_i), .cmd_hi_i(cmd_hi_i), .sender_i(sender_i),
        .tgt_id_i(tgt_id_i), .tgt_lid_i(tgt_lid_i), .tgt_fmt_i(tgt_fmt_i),
        .match_o(match_o), .valid_o(valid_o)
    );

    function automatic logic [N-1:0] model(input logic [31:0] lo, input logic [31:0] hi,
                                           input logic [1:0] snd);
        logic [N-1:0] v = '0;
        logic [N-1:0] p = '0;
        logic [7:0] d = hi[31:24];
        for (int k = 0; k < N; k++) begin
            logic [7:0] id = tgt_id_i[k*8 +: 8];
            logic [7:0] li = tgt_lid_i[k*8 +: 8];
            logic [3:0] f  = tgt_fmt_i[k*4 +: 4];
            case (lo[19:18])
                2'b01: v[k] = (k == int'(snd));
                2'b10: v[k] = 1'b1;
                2'b11: v[k] = (k != int'(snd));
                default: begin
                    if (!lo[11]) v[k] = (d == 8'hFF) || (d == id);
                    else if (f == 4'hF) v[k] = (li & d) != 0;
                    else if (f == 4'h0) v[k] = (li[7:4] == d[7:4]) && ((li[3:0] & d[3:0]) != 0);
                    else v[k] = 1'b0;
                end
            endcase
        end
        if (lo[10:8] == 3'b001) begin
            for (int k = 0; k < N; k++) if (v[k]) begin p = '0; p[k] = 1'b1; end
            return p;
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one message and check the registered result one cycle later.
    task automatic send(input string req, input logic [31:0] lo, input logic [31:0] hi,
                        input logic [1:0] snd);
        logic [N-1:0] exp;
        @(negedge clk);
        cmd_lo_i = lo; cmd_hi_i = hi; sender_i = snd; send_i = 1'b1;
        exp = model(lo, hi, snd);
        @(negedge clk);
        send_i = 1'b0;
        check({req, " valid"}, 32'(valid_o), 32'd1);
        check(req, 32'(match_o), 32'(exp));
    endtask

    function automatic logic [31:0] lo_word(input logic [1:0] sh, input logic lg, input logic [2:0] dm);
        return {12'h0, sh, 6'h0, lg, dm, 8'h31};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] held;
        void'($urandom(32'h1234));
        tgt_id_i  = {8'h03, 8'h02, 8'h01, 8'h00};
        tgt_lid_i = {8'h08, 8'h04, 8'h02, 8'h01};
        tgt_fmt_i = {4'hF, 4'hF, 4'hF, 4'hF};
        repeat (3) @(negedge clk);
        check("R1 match", 32'(match_o), 32'd0);
        check("R1 valid", 32'(valid_o), 32'd0);
        rst_n = 1'b1;

        send("R5 phys id",        lo_word(2'b00, 1'b0, 3'b000), 32'h02000000, 2'd0);
        send("R5 phys broadcast", lo_word(2'b00, 1'b0, 3'b000), 32'hFF000000, 2'd0);
        send("R10 hi noise",      lo_word(2'b00, 1'b0, 3'b000), 32'h01FFFFFF, 2'd0);
        send("R6 flat",           lo_word(2'b00, 1'b1, 3'b000), 32'h0A000000, 2'd0);
        send("R3 self",           lo_word(2'b01, 1'b0, 3'b000), 32'h0, 2'd2);
        send("R4 all",            lo_word(2'b10, 1'b0, 3'b000), 32'h0, 2'd1);
        send("R4 others",         lo_word(2'b11, 1'b0, 3'b000), 32'h0, 2'd1);
        send("R9 lowest multi",   lo_word(2'b00, 1'b1, 3'b001), 32'h07000000, 2'd0);
        send("R9 lowest none",    lo_word(2'b00, 1'b1, 3'b001), 32'h30000000, 2'd0);
        send("R9 lowest all",     lo_word(2'b10, 1'b0, 3'b001), 32'h0, 2'd0);

        tgt_lid_i = {8'h21, 8'h23, 8'h13, 8'h12};
        tgt_fmt_i = {4'h0, 4'h0, 4'h0, 4'h0};
        send("R7 cluster", lo_word(2'b00, 1'b1, 3'b000), 32'h21000000, 2'd0);
        send("R7 cluster2", lo_word(2'b00, 1'b1, 3'b000), 32'h12000000, 2'd0);
        tgt_fmt_i = {4'h5, 4'h0, 4'hF, 4'h7};
        send("R8 bad model", lo_word(2'b00, 1'b1, 3'b000), 32'hFF000000, 2'd0);
        check("R8 bad targets", 32'(match_o & 4'b1001), 32'd0);

        // Hold: change inputs without a send.
        held = match_o;
        @(negedge clk);
        cmd_lo_i = lo_word(2'b10, 1'b0, 3'b000);
        repeat (2) @(negedge clk);
        check("R2 valid low", 32'(valid_o), 32'd0);
        check("R2 hold", 32'(match_o), 32'(held));

        for (int i = 0; i < 400; i++) begin
            logic [31:0] lo;
            logic [7:0] pool [4] = '{8'h11, 8'h13, 8'h21, 8'h0F};
            for (int k = 0; k < N; k++) begin
                tgt_id_i[k*8 +: 8]  = 8'($urandom_range(0, 5));
                tgt_lid_i[k*8 +: 8] = pool[$urandom_range(0, 3)] | 8'($urandom_range(0, 1) << 2);
                case ($urandom_range(0, 3))
                    0: tgt_fmt_i[k*4 +: 4] = 4'h0;
                    1: tgt_fmt_i[k*4 +: 4] = 4'hA;
                    default: tgt_fmt_i[k*4 +: 4] = 4'hF;
                endcase
            end
            lo = $urandom;
            if ($urandom_range(0, 1) == 0) lo[19:18] = 2'b00;
            if ($urandom_range(0, 2) == 0) lo[10:8] = 3'b001;
            send("R5 R6 R7 R9 random", lo,
                 {($urandom_range(0, 9) == 0) ? 8'hFF : pool[$urandom_range(0, 3)] ^ 8'($urandom_range(0, 5)),
                  24'($urandom)},
                 2'($urandom_range(0, 3)));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule